// File: doc/BRIEF.md
# Three-Pin Shared GPIO and LED Controller

This block owns three chip pins that are shared between status LEDs and general-purpose I/O. A 32-bit register port sets each pin's role, direction, drive style and interrupt polarity, holds the output data and exposes sticky interrupt status and per-pin interrupt enables. On the pin side it produces an output enable and an output value for each pad and takes back the pad level. LED drive signals come from elsewhere in the chip, and one combined interrupt line leaves the block.

Each pin input passes through a two-flop synchronizer and then through a small qualifier state machine with three states. Q_IDLE waits for the active level. Q_IDLE goes to Q_COUNT when the active level appears. Q_COUNT goes to Q_HELD after QUAL_CYC consecutive active samples, and goes back to Q_IDLE on any inactive sample. Q_HELD goes to Q_IDLE when the level becomes inactive. QUAL_CYC is ceil(MIN_NS / CLK_NS), which is 8 cycles for a 40 ns minimum at a 5 ns clock. While the machine is in Q_HELD, it sets the pin's status bit on every cycle.

The register map uses byte addresses. The configuration register is at 0x0, the data register at 0x4, the status register at 0x8 and the enable register at 0xC. Pin i is controlled by bit i of each field.

Top module: `gpio_led_ctrl`

## Requirements
- R1: After reset, every configuration field, the status register and the enable register read zero, all pin output enables are 0 and irq is 0.
- R2: In the configuration register, bits 30:28 are LED mode, bits 26:24 are polarity, bits 18:16 are drive type (1 = push-pull, 0 = open-drain) and bits 10:8 are direction (1 = output), for pins 0, 1 and 2 in that order. All other bits read zero and ignore writes, so writing 0xFFFFFFFF reads back 0x77070700.
- R3: In LED mode a pin has pin_oe=1 and pin_out equal to its led_src bit, whatever its direction and drive settings.
- R4: A GPIO output pin with push-pull drive has pin_oe=1 and pin_out equal to its data bit.
- R5: A GPIO output pin with open-drain drive has pin_out=0 and pin_oe equal to the inverse of its data bit.
- R6: A GPIO input pin has pin_oe=0. Its data register bit (0x4, bit i) returns the pin level two clock edges after the level is applied.
- R7: For a GPIO output pin, the data register bit returns the last value written.
- R8: With polarity 1, a high pin level sets the pin's status bit (0x8, bit i). With polarity 0, a low level sets it.
- R9: An active level held for fewer than QUAL_CYC consecutive cycles leaves the status bit clear. A level held for at least QUAL_CYC cycles sets it.
- R10: Status bits stay set until they are cleared by writing 1 to them. A bit whose active level is still present is set again at once.
- R11: irq is 1 exactly when some status bit and its enable bit (0xC, bit i) are both 1.
- R12: A pin in LED mode never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | 3 | Pad input levels |
| pin_oe | output | 3 | Pad output enables |
| pin_out | output | 3 | Pad output values |
| led_src | input | 3 | LED drive signals from the chip |
| irq | output | 1 | Combined interrupt |

## Verification
The pulse-width boundary is the hardest case to reach from the ports. The input passes through two synchronizer stages before the qualifier counts it, so the bench holds the pin at the active level for an exact number of clock edges, changing it only on falling edges. One pulse is one cycle short of QUAL_CYC and must be rejected, and one is longer and must be accepted. The re-set case is reached by clearing a status bit while the active level is still held steady, then reading the bit back immediately.

// File: rtl/gpio_led_pkg.sv
package gpio_led_pkg;
    localparam int NPIN    = 3;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;

    localparam int LED_LSB = 28;
    localparam int POL_LSB = 24;
    localparam int PP_LSB  = 16;
    localparam int DIR_LSB = 8;

    localparam logic [ADDR_W-3:0] SEL_CFG  = 2'd0;
    localparam logic [ADDR_W-3:0] SEL_DATA = 2'd1;
    localparam logic [ADDR_W-3:0] SEL_STS  = 2'd2;
    localparam logic [ADDR_W-3:0] SEL_EN   = 2'd3;

    typedef struct packed {
        logic [NPIN-1:0] led;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] pp;
        logic [NPIN-1:0] dir;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_COUNT = 2'd1,
        Q_HELD  = 2'd2
    } qual_state_e;
endpackage

// File: rtl/gpio_irq_qual.sv
module gpio_irq_qual
    import gpio_led_pkg::*;
#(
    parameter int QUAL_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic qualified
);
    localparam int CNT_W = $clog2(QUAL_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYC - 1);

    qual_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            Q_IDLE: begin
                cnt_d = '0;
                if (active) begin
                    if (QUAL_CYC <= 1) begin
                        state_d = Q_HELD;
                    end else begin
                        state_d = Q_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            Q_COUNT: begin
                if (!active) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = Q_HELD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            Q_HELD: begin
                cnt_d = '0;
                if (!active) state_d = Q_IDLE;
            end
            default: begin
                state_d = Q_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        qualified = (state_q == Q_HELD);
    end

    AST_QUAL_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(active)); // R9
    AST_QUAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (qualified && !active) |=> !qualified); // R9
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic led_mode,
    input  logic dir_out,
    input  logic push_pull,
    input  logic data_bit,
    input  logic led_bit,
    output logic oe,
    output logic out
);
    always_comb begin
        if (led_mode) begin
            oe  = 1'b1;
            out = led_bit;
        end else if (!dir_out) begin
            oe  = 1'b0;
            out = 1'b0;
        end else if (push_pull) begin
            oe  = 1'b1;
            out = data_bit;
        end else begin
            oe  = ~data_bit;
            out = 1'b0;
        end
    end

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_mode && !push_pull) |-> !(oe && out)); // R5
    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_mode && !dir_out) |-> !oe); // R6
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_led_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPIN-1:0]   pin_sync,
    input  logic [NPIN-1:0]   qual,
    output pin_cfg_t          cfg,
    output logic [NPIN-1:0]   data_q,
    output logic [NPIN-1:0]   sts_q,
    output logic [NPIN-1:0]   en_q
);
    logic [ADDR_W-3:0] sel;
    logic              aligned;
    logic              wr_cfg, wr_data, wr_sts, wr_en;
    logic [NPIN-1:0]   gpio_out;

    assign sel     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_cfg  = wen && aligned && (sel == SEL_CFG);
    assign wr_data = wen && aligned && (sel == SEL_DATA);
    assign wr_sts  = wen && aligned && (sel == SEL_STS);
    assign wr_en   = wen && aligned && (sel == SEL_EN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg    <= '0;
            data_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_cfg) begin
                cfg.led <= wdata[LED_LSB +: NPIN];
                cfg.pol <= wdata[POL_LSB +: NPIN];
                cfg.pp  <= wdata[PP_LSB  +: NPIN];
                cfg.dir <= wdata[DIR_LSB +: NPIN];
            end
            if (wr_data) data_q <= wdata[NPIN-1:0];
            if (wr_en)   en_q   <= wdata[NPIN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~(wr_sts ? wdata[NPIN-1:0] : '0)) | qual;
        end
    end

    assign gpio_out = cfg.dir & ~cfg.led;

    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_CFG: begin
                    rdata[LED_LSB +: NPIN] = cfg.led;
                    rdata[POL_LSB +: NPIN] = cfg.pol;
                    rdata[PP_LSB  +: NPIN] = cfg.pp;
                    rdata[DIR_LSB +: NPIN] = cfg.dir;
                end
                SEL_DATA: rdata[NPIN-1:0] = (gpio_out & data_q) | (~gpio_out & pin_sync);
                SEL_STS:  rdata[NPIN-1:0] = sts_q;
                SEL_EN:   rdata[NPIN-1:0] = en_q;
                default:  rdata = '0;
            endcase
        end
    end

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sts |=> ((($past(sts_q)) & ~sts_q) == '0)); // R10
    AST_QUAL_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
        (qual != '0) |=> ((sts_q & $past(qual)) == $past(qual))); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && sel == SEL_CFG) |-> ((rdata & 32'h88F8F8FF) == '0)); // R2
endmodule

// File: rtl/gpio_led_ctrl.sv
module gpio_led_ctrl
    import gpio_led_pkg::*;
#(
    parameter int CLK_NS = 5,
    parameter int MIN_NS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_out,
    input  logic [NPIN-1:0]   led_src,
    output logic              irq
);
    localparam int QUAL_CYC = (MIN_NS + CLK_NS - 1) / CLK_NS;

    pin_cfg_t        cfg;
    logic [NPIN-1:0] data_q, sts_q, en_q;
    logic [NPIN-1:0] sync1_q, sync2_q;
    logic [NPIN-1:0] active, qual;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    gpio_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (reg_wen),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .pin_sync (sync2_q),
        .qual     (qual),
        .cfg      (cfg),
        .data_q   (data_q),
        .sts_q    (sts_q),
        .en_q     (en_q)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign active[i] = (sync2_q[i] == cfg.pol[i]) && !cfg.led[i];

        gpio_irq_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (active[i]),
            .qualified (qual[i])
        );

        gpio_pin_mux u_mux (
            .clk       (clk),
            .rst_n     (rst_n),
            .led_mode  (cfg.led[i]),
            .dir_out   (cfg.dir[i]),
            .push_pull (cfg.pp[i]),
            .data_bit  (data_q[i]),
            .led_bit   (led_src[i]),
            .oe        (pin_oe[i]),
            .out       (pin_out[i])
        );

        AST_LED_NO_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.led[i] && $past(cfg.led[i])) |-> !qual[i]); // R12
    end

    assign irq = |(sts_q & en_q);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != '0)); // R11
endmodule

// File: tb/test_gpio_led_ctrl.sv
module test_gpio_led_ctrl;
    localparam int QC = 8;
    localparam logic [3:0] A_CFG = 4'h0, A_DATA = 4'h4, A_STS = 4'h8, A_EN = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  pin_in = 3'b111;
    logic [2:0]  pin_oe, pin_out;
    logic [2:0]  led_src = 3'b000;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_led_ctrl i_gpio_led_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .led_src(led_src), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CFG, v);  check("R1 cfg", v, 0);
        rd(A_STS, v);  check("R1 sts", v, 0);
        rd(A_EN, v);   check("R1 en", v, 0);
        check("R1 oe", {29'd0, pin_oe}, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v); check("R2 readback", v, 32'h7707_0700);
        wr(A_CFG, 32'h0);
    endtask

    task automatic t_drive;
        logic [31:0] v;
        // pin0 push-pull out, pin1 open-drain out, pin2 LED with dir=0
        wr(A_DATA, 32'h1);
        wr(A_CFG, 32'h4001_0300);
        led_src = 3'b100;
        #1;
        check("R4 pp oe/out", {30'd0, pin_oe[0], pin_out[0]}, 32'b11);
        check("R5 od data0", {30'd0, pin_oe[1], pin_out[1]}, 32'b10);
        check("R3 led on", {30'd0, pin_oe[2], pin_out[2]}, 32'b11);
        wr(A_DATA, 32'h2);
        led_src = 3'b000;
        #1;
        check("R4 pp data0", {30'd0, pin_oe[0], pin_out[0]}, 32'b10);
        check("R5 od data1", {30'd0, pin_oe[1], pin_out[1]}, 32'b00);
        check("R3 led off", {30'd0, pin_oe[2], pin_out[2]}, 32'b10);
        // pin_in[2] is 1 (LED pin, not GPIO output) so data reads sync level
        rd(A_DATA, v); check("R7 data readback", v, 32'h6);
        wr(A_CFG, 32'h0);
    endtask

    task automatic t_input;
        logic [31:0] v;
        #1; check("R6 input oe", {29'd0, pin_oe}, 0);
        wr(A_CFG, 32'h0100_0000);   // pin0 polarity high so its low level is inactive
        @(negedge clk); pin_in[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(A_DATA, v); check("R6 input level low", v, 32'h6);
        pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_DATA, v); check("R6 input level high", v, 32'h7);
        wr(A_CFG, 32'h0);
        wr(A_STS, 32'h7);
        rd(A_STS, v); check("R10 clear", v, 0);
    endtask

    task automatic t_width;
        logic [31:0] v;
        // polarity 0: low level active on pin1
        @(negedge clk); pin_in[1] = 1'b0;
        wait_cyc(QC - 1); pin_in[1] = 1'b1;
        wait_cyc(6);
        rd(A_STS, v); check("R9 short pulse rejected", v, 0);
        pin_in[1] = 1'b0;
        wait_cyc(QC + 2); pin_in[1] = 1'b1;
        wait_cyc(6);
        rd(A_STS, v); check("R8 low polarity sets", v, 32'h2);
        wait_cyc(4);
        rd(A_STS, v); check("R10 sticky", v, 32'h2);
        check("R11 irq disabled", {31'd0, irq}, 0);
        wr(A_EN, 32'h2); #1;
        check("R11 irq enabled", {31'd0, irq}, 1);
        wr(A_EN, 32'h5); #1;
        check("R11 other enables", {31'd0, irq}, 0);
        wr(A_STS, 32'h2);
        rd(A_STS, v); check("R10 w1c", v, 0);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_polarity;
        logic [31:0] v;
        wr(A_CFG, 32'h0100_0000);  // pin0 high-active, pin0 level already high
        wait_cyc(QC + 4);
        rd(A_STS, v); check("R8 high polarity sets", v, 32'h1);
        wr(A_STS, 32'h1);
        rd(A_STS, v); check("R10 reset while active", v, 32'h1);
        wr(A_CFG, 32'h0);
        wait_cyc(2);
        wr(A_STS, 32'h7);
        // LED mode on pin2 with its active level present
        wr(A_CFG, 32'h4000_0000);
        pin_in[2] = 1'b0;
        wait_cyc(QC + 6);
        rd(A_STS, v); check("R12 led no status", v, 0);
        pin_in[2] = 1'b1;
        wr(A_CFG, 32'h0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_reserved();
        t_drive();
        t_input();
        t_width();
        t_polarity();
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule